// File: doc/BRIEF.md
# Peripheral Set/Clear Interrupt Register File

This block gives a peripheral its standard register set on a 32-bit APB-style bus. It has a write-only command register, a read/write mode register, a read-only status window and an interrupt mask. The command register raises one-cycle pulses toward the peripheral. The mode register holds its configuration. The status window shows the status bits that the peripheral drives in. The interrupt request line is the OR of the status bits ANDed with the mask bits, and it goes to an interrupt controller.

Software never changes the mask with a read-modify-write. An enable register sets mask bits, a disable register clears them, and a read-only register returns the current value. A combined update register carries set bits in its low half and clear bits in its high half, and clear wins when both name the same bit. Every access counts as a full word: the two lowest address bits are ignored. Bits that a register does not implement read as zero. Write-only registers and unmapped offsets read as zero. Writes to read-only registers have no effect.

Top module: `psc_regs`

## Requirements
- R1: After reset the mask is all zeros, the mode register is 0, `irq_o` is 0 and `cmd_o` is 0.
- R2: A write to offset 0x0C sets every mask bit whose `pwdata` bit is 1. Bits written as 0 leave the mask unchanged.
- R3: A write to offset 0x10 clears every mask bit whose `pwdata` bit is 1. Bits written as 0 leave the mask unchanged.
- R4: A read of offset 0x14 returns the mask in bits [N_IRQ-1:0] and zero in every bit above.
- R5: `irq_o` is 1 exactly when some bit is 1 in both `sts_i` and the mask. It follows `sts_i` within the same cycle.
- R6: A write to offset 0x18 sets mask bits from `pwdata[N_IRQ-1:0]` and clears mask bits from `pwdata[16+N_IRQ-1:16]`. A bit named in both halves ends up cleared.
- R7: A write to offset 0x00 drives `cmd_o` with `pwdata[CMD_W-1:0]` for exactly the one cycle after the write edge. After that cycle `cmd_o` returns to 0. A zero bit triggers nothing.
- R8: Offset 0x04 is read/write. It stores `pwdata[MODE_W-1:0]` and reads back zero above bit MODE_W-1.
- R9: A read of offset 0x08 returns `sts_i` zero-extended. A write to 0x08 changes neither the mode register nor the mask.
- R10: `paddr[1:0]` is ignored, so an access at any byte of a word acts on that word.
- R11: Reads of the write-only offsets 0x00, 0x0C, 0x10 and 0x18, and of any unmapped offset, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Block selected |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address, low two bits ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while a read is selected |
| sts_i | input | N_IRQ | Status bits from the peripheral |
| cmd_o | output | CMD_W | One-cycle command pulses |
| mode_o | output | MODE_W | Current mode value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with N_IRQ=10, CMD_W=5 and MODE_W=12. None of these widths is a multiple of eight. Writing all ones to the mask, mode and command registers therefore shows whether the reserved bits read as zero and whether the surplus write bits are dropped. It also checks that the clear half of the update register, which starts at bit 16, stays apart from the set half. With ten interrupt bits, a full set followed by a combined set-and-clear on the same bit exercises the clear-wins rule. Some accesses use nonzero byte offsets to show that the low address bits are ignored.

// File: rtl/psc_pkg.sv
// Package: shared register indices and decode type for the set/clear
// register file. Assumes word-aligned registers in a small address window.
package psc_pkg;
    localparam int unsigned IDX_CMD  = 0;   // 0x00 command, write-only
    localparam int unsigned IDX_MODE = 1;   // 0x04 mode, read/write
    localparam int unsigned IDX_STAT = 2;   // 0x08 status, read-only
    localparam int unsigned IDX_IEN  = 3;   // 0x0C mask set, write-only
    localparam int unsigned IDX_IDIS = 4;   // 0x10 mask clear, write-only
    localparam int unsigned IDX_IMSK = 5;   // 0x14 mask value, read-only
    localparam int unsigned IDX_MUPD = 6;   // 0x18 combined set/clear, write-only
    localparam int unsigned CLR_LSB  = 16;  // clear half of the combined register

    typedef struct packed {
        logic cmd;
        logic mode;
        logic stat;
        logic ien;
        logic idis;
        logic imsk;
        logic mupd;
    } psc_sel_t;
endpackage

// File: rtl/psc_decode.sv
// Module: word address decoder. Drops the two byte-lane bits and turns the
// word index into one select per register. Unmapped indices select nothing.
module psc_decode
    import psc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output psc_sel_t          sel_o
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_lane;

    assign idx         = addr_i[ADDR_W-1:2];
    assign unused_lane = addr_i[1:0];

    // Compare the word index against each register slot.
    always_comb begin
        sel_o      = '0;
        sel_o.cmd  = (idx == IDX_W'(IDX_CMD));
        sel_o.mode = (idx == IDX_W'(IDX_MODE));
        sel_o.stat = (idx == IDX_W'(IDX_STAT));
        sel_o.ien  = (idx == IDX_W'(IDX_IEN));
        sel_o.idis = (idx == IDX_W'(IDX_IDIS));
        sel_o.imsk = (idx == IDX_W'(IDX_IMSK));
        sel_o.mupd = (idx == IDX_W'(IDX_MUPD));
    end
endmodule

// File: rtl/psc_setclr.sv
// Module: bit-wise set/clear register. Each bit is set by a one on set_i and
// cleared by a one on clr_i, and clear wins when both are one. Assumes the
// set and clear vectors are already qualified by the write strobes.
module psc_setclr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // One flop per bit: apply the set, then the clear.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)          q_o[b] <= 1'b0;
            else if (clr_i[b])   q_o[b] <= 1'b0;
            else if (set_i[b])   q_o[b] <= 1'b1;
        end
    end
endmodule

// File: rtl/psc_hold.sv
// Module: plain loadable register that resets to zero. Used for the mode
// field. Assumes we_i is a one-cycle qualified write strobe.
module psc_hold #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Load on write, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (we_i) q_o <= d_i;
    end
endmodule

// File: rtl/psc_pulse.sv
// Module: command pulse generator. A write loads the command bits for one
// cycle, after which the output falls back to zero. Assumes writes are not
// back to back (a bus transfer takes two cycles).
module psc_pulse #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Present the written command bits for a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (we_i) q_o <= d_i;
        else           q_o <= '0;
    end
endmodule

// File: rtl/psc_irq.sv
// Module: interrupt combiner. ANDs every status bit with its mask bit and
// ORs the results into one request. Purely combinational.
module psc_irq #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] sts_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    logic [W-1:0] hit;

    for (genvar b = 0; b < W; b++) begin : g_hit
        assign hit[b] = sts_i[b] & mask_i[b];
    end

    // Reduce the per-bit hits to one line.
    always_comb irq_o = |hit;
endmodule

// File: rtl/psc_regs.sv
// Module: top of the set/clear register file. Decodes APB-style word
// accesses, updates the command, mode and mask registers, muxes read data
// and drives the interrupt line. Assumes N_IRQ <= 16 (the combined update
// register splits the word at bit 16) and CMD_W, MODE_W <= 32.
module psc_regs
    import psc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned N_IRQ  = 8,
    parameter int unsigned CMD_W  = 4,
    parameter int unsigned MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [N_IRQ-1:0]  sts_i,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              irq_o
);
    localparam int unsigned CLR_MSB = CLR_LSB + N_IRQ - 1;

    psc_sel_t         sel;
    logic             wr;
    logic             rd;
    logic             wr_cmd;
    logic             wr_mode;
    logic             wr_ien;
    logic             wr_idis;
    logic             wr_mupd;
    logic [N_IRQ-1:0] mask;
    logic [N_IRQ-1:0] mask_set;
    logic [N_IRQ-1:0] mask_clr;
    logic             unused_stat_wr;

    psc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (paddr),
        .sel_o  (sel)
    );

    assign wr      = psel & penable & pwrite;
    assign rd      = psel & ~pwrite;
    assign wr_cmd  = wr & sel.cmd;
    assign wr_mode = wr & sel.mode;
    assign wr_ien  = wr & sel.ien;
    assign wr_idis = wr & sel.idis;
    assign wr_mupd = wr & sel.mupd;
    // Status and mask readback registers take no writes.
    assign unused_stat_wr = wr & (sel.stat | sel.imsk);

    // Gather the set and clear vectors from the three mask write paths.
    always_comb begin
        mask_set = '0;
        mask_clr = '0;
        if (wr_ien)  mask_set = pwdata[N_IRQ-1:0];
        if (wr_idis) mask_clr = pwdata[N_IRQ-1:0];
        if (wr_mupd) begin
            mask_set = pwdata[N_IRQ-1:0];
            mask_clr = pwdata[CLR_MSB:CLR_LSB];
        end
    end

    psc_setclr #(.W(N_IRQ)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (mask_set),
        .clr_i (mask_clr),
        .q_o   (mask)
    );

    psc_hold #(.W(MODE_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (wr_mode),
        .d_i   (pwdata[MODE_W-1:0]),
        .q_o   (mode_o)
    );

    psc_pulse #(.W(CMD_W)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (wr_cmd),
        .d_i   (pwdata[CMD_W-1:0]),
        .q_o   (cmd_o)
    );

    psc_irq #(.W(N_IRQ)) u_irq (
        .sts_i  (sts_i),
        .mask_i (mask),
        .irq_o  (irq_o)
    );

    // Read mux: readable registers zero-extended, everything else zero.
    always_comb begin
        prdata = '0;
        if (rd) begin
            if (sel.mode) prdata = 32'(mode_o);
            if (sel.stat) prdata = 32'(sts_i);
            if (sel.imsk) prdata = 32'(mask);
        end
    end
endmodule

// File: rtl/psc_regs_chk.sv
// Module: assertion checker for psc_regs, attached by bind below.
module psc_regs_chk #(
    parameter int unsigned N_IRQ = 8,
    parameter int unsigned CMD_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_cmd,
    input logic             wr_ien,
    input logic             wr_idis,
    input logic             wr_mupd,
    input logic [31:0]      pwdata,
    input logic [N_IRQ-1:0] mask,
    input logic [N_IRQ-1:0] sts_i,
    input logic             irq_o,
    input logic [CMD_W-1:0] cmd_o
);
    localparam int unsigned CLR_LSB = 16;

    a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ien |=> ((mask & $past(pwdata[N_IRQ-1:0])) == $past(pwdata[N_IRQ-1:0])));

    a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ien || wr_idis || wr_mupd) |=> $stable(mask));

    a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idis |=> ((mask & $past(pwdata[N_IRQ-1:0])) == '0));

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mupd |=> ((mask & $past(pwdata[CLR_LSB+N_IRQ-1:CLR_LSB])) == '0));

    a_r5_irq_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((sts_i & mask) != '0));

    a_r5_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);

    a_r7_cmd_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != '0) |-> $past(wr_cmd));

    a_r7_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != '0) |=> (cmd_o == '0));
endmodule

bind psc_regs psc_regs_chk #(.N_IRQ(N_IRQ), .CMD_W(CMD_W)) u_psc_regs_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cmd  (wr_cmd),
    .wr_ien  (wr_ien),
    .wr_idis (wr_idis),
    .wr_mupd (wr_mupd),
    .pwdata  (pwdata),
    .mask    (mask),
    .sts_i   (sts_i),
    .irq_o   (irq_o),
    .cmd_o   (cmd_o)
);

// File: tb/test_psc_regs.sv
`timescale 1ns/1ps
module test_psc_regs;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned N_IRQ  = 10;
    localparam int unsigned CMD_W  = 5;
    localparam int unsigned MODE_W = 12;

    localparam logic [7:0] A_CMD  = 8'h00;
    localparam logic [7:0] A_MODE = 8'h04;
    localparam logic [7:0] A_STAT = 8'h08;
    localparam logic [7:0] A_IEN  = 8'h0C;
    localparam logic [7:0] A_IDIS = 8'h10;
    localparam logic [7:0] A_IMSK = 8'h14;
    localparam logic [7:0] A_MUPD = 8'h18;

    localparam int SRC_RD  = 0;
    localparam int SRC_IRQ = 1;
    localparam int SRC_CMD = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              psel = 1'b0;
    logic              penable = 1'b0;
    logic              pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata;
    logic [N_IRQ-1:0]  sts_i = '0;
    logic [CMD_W-1:0]  cmd_o;
    logic [MODE_W-1:0] mode_o;
    logic              irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        int          src;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    event  smp;

    psc_regs #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ), .CMD_W(CMD_W), .MODE_W(MODE_W)) i_psc_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .sts_i(sts_i),
        .cmd_o(cmd_o), .mode_o(mode_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    // Monitor: pop the next expected item and compare it with the design.
    always @(smp) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.src)
                SRC_IRQ: act = 32'(irq_o);
                SRC_CMD: act = 32'(cmd_o);
                default: act = prdata;
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    // Driver side: queue an expectation and let the monitor sample it.
    task automatic expect_now(input int src, input logic [31:0] e, input string tag);
        item_t it;
        it.src = src; it.exp = e; it.tag = tag;
        sb.push_back(it);
        #1;
        -> smp;
        #1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pwdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        expect_now(SRC_RD, e, tag);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic set_sts(input logic [N_IRQ-1:0] s);
        @(negedge clk);
        sts_i = s;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        expect_now(SRC_CMD, 32'h0, "R1 cmd after reset");
        sts_i = '1;
        expect_now(SRC_IRQ, 32'h0, "R1 irq after reset");
        bus_read(A_IMSK, 32'h0, "R1 mask after reset");
        bus_read(A_MODE, 32'h0, "R1 mode after reset");

        // R2: enable sets ones, zeros ignored
        bus_write(A_IEN, 32'h0000_0005);
        bus_read(A_IMSK, 32'h005, "R2 enable sets bits");
        expect_now(SRC_IRQ, 32'h1, "R5 irq with hit");
        bus_write(A_IEN, 32'h0);
        bus_read(A_IMSK, 32'h005, "R2 zero write ignored");

        // R5: irq follows status AND mask
        set_sts(10'h002);
        expect_now(SRC_IRQ, 32'h0, "R5 status outside mask");
        set_sts(10'h004);
        expect_now(SRC_IRQ, 32'h1, "R5 status inside mask");

        // R3: disable clears ones, zeros ignored
        bus_write(A_IDIS, 32'h0000_0001);
        bus_read(A_IMSK, 32'h004, "R3 disable clears bit");
        bus_write(A_IDIS, 32'hFFFF_FC00);
        bus_read(A_IMSK, 32'h004, "R3 zero bits ignored");

        // R4: readback above N_IRQ is zero
        bus_write(A_IEN, 32'hFFFF_FFFF);
        bus_read(A_IMSK, 32'h3FF, "R4 upper mask bits zero");

        // R6: combined update, clear wins on bit 0
        bus_write(A_MUPD, 32'h0003_0001);
        bus_read(A_IMSK, 32'h3FC, "R6 clear wins");

        // R8: mode register
        bus_write(A_MODE, 32'hFFFF_FFFF);
        bus_read(A_MODE, 32'hFFF, "R8 mode upper bits zero");
        bus_write(A_MODE, 32'h0000_0ABC);
        bus_read(A_MODE, 32'hABC, "R8 mode readback");

        // R9: status read and write ignored
        set_sts(10'h155);
        bus_read(A_STAT, 32'h155, "R9 status read");
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_read(A_MODE, 32'hABC, "R9 mode after status write");
        bus_read(A_IMSK, 32'h3FC, "R9 mask after status write");

        // R7: command pulses
        bus_write(A_CMD, 32'h0000_0013);
        expect_now(SRC_CMD, 32'h13, "R7 command pulse");
        @(negedge clk);
        expect_now(SRC_CMD, 32'h0, "R7 pulse ends");
        bus_write(A_CMD, 32'hFFFF_FFE0);
        expect_now(SRC_CMD, 32'h0, "R7 zero bits trigger nothing");

        // R11: write-only and unmapped reads return zero
        bus_read(A_CMD,  32'h0, "R11 command reads zero");
        bus_read(A_IEN,  32'h0, "R11 enable reads zero");
        bus_read(A_IDIS, 32'h0, "R11 disable reads zero");
        bus_read(A_MUPD, 32'h0, "R11 update reads zero");
        bus_read(8'h1C,  32'h0, "R11 unmapped reads zero");
        bus_read(8'hFC,  32'h0, "R11 top offset reads zero");

        // R10: byte offsets act on the word
        bus_write(A_IDIS | 8'h2, 32'h0000_03FC);
        bus_read(A_IMSK | 8'h3, 32'h0, "R10 offset write and read");
        bus_read(A_MODE | 8'h1, 32'hABC, "R10 offset mode read");
        set_sts('1);
        expect_now(SRC_IRQ, 32'h0, "R5 empty mask no irq");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule